// File: doc/BRIEF.md
# Serial Byte Transmitter with Early and Final Completion Flags

This block takes bytes from a host over a valid/ready write port and holds them in an eight-entry queue. It sends each byte on a single line as an asynchronous serial frame: a low start bit, the data bits starting with the least significant, an optional parity bit, and one or two high stop bits. Every bit lasts a fixed number of pulses of an externally supplied baud tick. Parity enable, parity sense and stop-bit count are plain level inputs. The host must hold them steady while a frame is in flight.

Two status levels with different timing let software, or a neighbouring block, tell how far a send has progressed. The early flag rises when the last data bit of the final queued byte has left the line, while the parity and stop bits are still going out. The final flag rises only when the queue is empty and the last stop bit has been driven for its full bit time. After that the line stays idle. The driver-enable output for a half-duplex differential transceiver is the inverse of the final flag. It therefore never drops while a bit is still on the wire. When it turns back on, it leads the next start bit by one full bit time.

Back-pressure rules of the write port: a byte moves on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly when the queue holds eight bytes. While `wr_ready` is low, the host keeps `wr_valid` and `wr_data` unchanged, and nothing is taken. `wr_ready` depends only on internal state, never on `wr_valid`.

Top module: `uart_tx_de`

## Requirements
- R1: After a synchronous active-high reset, the outputs are as follows: `txd`=1, `tx_done`=1, `data_sent`=1, `drv_en`=0 and `wr_ready`=1, and the queue is empty.
- R2: Each frame starts with a low start bit, followed by the 8 data bits sent least significant bit first. Every bit lasts 16 `baud_tick` pulses.
- R3: When `par_en`=1, a parity bit follows the data. Its value is the XOR of the 8 data bits XOR `par_odd` (1 selects odd, 0 selects even). When `par_en`=0, no parity bit is sent.
- R4: After the data (and the parity bit, if enabled), the line is driven high for one stop bit when `two_stop`=0, or for two stop bits when `two_stop`=1.
- R5: `data_sent` is low while a data bit of any frame is on the line. It rises at the edge that ends the last data bit when the queue is empty, so it is high during the parity and stop bits of the final frame.
- R6: `tx_done` rises at the edge that ends the last stop bit of a frame only if the queue is then empty. While `tx_done` is high, `txd` is high.
- R7: `drv_en` is high from the edge that accepts a byte into an idle block until the edge where `tx_done` rises, and it falls on that same edge.
- R8: A byte accepted while `tx_done` is high makes `tx_done` and `data_sent` fall, and `drv_en` rise, on the accepting edge. The start bit then follows after at least one full bit time of high line.
- R9: The queue holds 8 bytes. `wr_ready` is low while it is full. A write held during that time is taken later, without loss and in order. A frame whose end finds the queue non-empty is followed at once by the next start bit, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Host offers a byte |
| wr_data | input | 8 | Byte offered |
| wr_ready | output | 1 | Queue can take a byte |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| par_en | input | 1 | 1 adds a parity bit |
| par_odd | input | 1 | 1 odd parity, 0 even |
| two_stop | input | 1 | 1 sends two stop bits |
| txd | output | 1 | Serial line, idles high |
| data_sent | output | 1 | Early flag: last data bit of final byte has left |
| tx_done | output | 1 | Final flag: queue empty and line idle |
| drv_en | output | 1 | Transceiver driver enable |

## Verification
The properties assume that `baud_tick` is a single-cycle pulse. They also assume that `par_en`, `par_odd` and `two_stop` only change while `tx_done` is high, and that a writer facing a low `wr_ready` holds its byte. The stimulus follows these rules. It pulses the tick on every second clock and changes the frame settings only after the final flag has been seen. The write task keeps `wr_valid` and `wr_data` steady until it sees `wr_ready` high. The full-queue case is reached by writing ten bytes during the lead-in bit time, before the serializer takes its first byte.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_START = 3'd2,
    PH_DATA  = 3'd3,
    PH_PAR   = 3'd4,
    PH_STOP1 = 3'd5,
    PH_STOP2 = 3'd6
  } tx_phase_e;

  function automatic logic phase_is_tail(tx_phase_e ph);
    return (ph == PH_PAR) || (ph == PH_STOP1) || (ph == PH_STOP2);
  endfunction
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam bit POW2 = (DEPTH == (1 << AW));

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr, wptr_nx, rptr_nx;
  logic [CW-1:0]    count;

  generate
    if (POW2) begin : g_wrap_free
      assign wptr_nx = wptr + 1'b1;
      assign rptr_nx = rptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    end
  endgenerate

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wptr_nx;
      if (pop)  rptr <= rptr_nx;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TICKS  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_head,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic              pop,
  output logic              txd,
  output tx_phase_e         phase
);
  localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [TW-1:0]     tcnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  logic              parb;
  logic              bit_end;
  logic              last_stop;
  tx_phase_e         phase_nx;

  assign bit_end   = tick && (tcnt == TW'(TICKS - 1));
  assign last_stop = bit_end &&
                     (((phase == PH_STOP1) && !two_stop) || (phase == PH_STOP2));
  assign pop       = (bit_end && (phase == PH_LEAD)) || (last_stop && !q_empty);

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE:  if (!q_empty) phase_nx = PH_LEAD;
      PH_LEAD:  if (bit_end) phase_nx = PH_START;
      PH_START: if (bit_end) phase_nx = PH_DATA;
      PH_DATA:  if (bit_end && (idx == IW'(DATA_W - 1)))
                  phase_nx = par_en ? PH_PAR : PH_STOP1;
      PH_PAR:   if (bit_end) phase_nx = PH_STOP1;
      PH_STOP1, PH_STOP2: begin
        if (bit_end && (phase == PH_STOP1) && two_stop) phase_nx = PH_STOP2;
        else if (last_stop) phase_nx = q_empty ? PH_IDLE : PH_START;
      end
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      tcnt  <= '0;
      idx   <= '0;
      shreg <= '0;
      parb  <= 1'b0;
    end else begin
      phase <= phase_nx;
      if (phase == PH_IDLE)  tcnt <= '0;
      else if (bit_end)      tcnt <= '0;
      else if (tick)         tcnt <= tcnt + 1'b1;
      if (pop) begin
        shreg <= q_head;
        parb  <= (^q_head) ^ par_odd;
        idx   <= '0;
      end else if (bit_end && (phase == PH_DATA)) begin
        shreg <= shreg >> 1;
        idx   <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    case (phase)
      PH_START: txd = 1'b0;
      PH_DATA:  txd = shreg[0];
      PH_PAR:   txd = parb;
      default:  txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/tx_status.sv
module tx_status
  import uart_tx_pkg::*;
(
  input  logic      q_empty,
  input  tx_phase_e phase,
  output logic      data_sent,
  output logic      tx_done,
  output logic      drv_en
);
  logic line_idle;

  assign line_idle = (phase == PH_IDLE);
  assign tx_done   = q_empty && line_idle;
  assign data_sent = q_empty && (line_idle || phase_is_tail(phase));
  assign drv_en    = !tx_done;
endmodule

// File: rtl/uart_tx_de.sv
module uart_tx_de
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int TICKS      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              baud_tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic              txd,
  output logic              data_sent,
  output logic              tx_done,
  output logic              drv_en
);
  logic              q_full, q_empty, q_pop, q_push;
  logic [DATA_W-1:0] q_head;
  tx_phase_e         phase;

  assign wr_ready = !q_full;
  assign q_push   = wr_valid && wr_ready;

  tx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(q_push), .push_data(wr_data),
    .pop(q_pop), .head(q_head), .full(q_full), .empty(q_empty)
  );

  tx_serializer #(.DATA_W(DATA_W), .TICKS(TICKS)) u_ser (
    .clk(clk), .rst(rst), .tick(baud_tick), .q_empty(q_empty),
    .q_head(q_head), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .pop(q_pop), .txd(txd), .phase(phase)
  );

  tx_status u_stat (
    .q_empty(q_empty), .phase(phase),
    .data_sent(data_sent), .tx_done(tx_done), .drv_en(drv_en)
  );
endmodule

// File: rtl/uart_tx_de_chk.sv
module uart_tx_de_chk (
  input logic clk,
  input logic rst,
  input logic txd,
  input logic data_sent,
  input logic tx_done,
  input logic drv_en
);
  // R6
  done_line_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> txd);

  // R6
  done_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> $past(txd));

  // R5
  early_before_done_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> data_sent);

  // R5
  early_rise_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_sent) |-> !tx_done);

  // R8
  lead_before_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(txd) |-> $past(drv_en));

  // R7
  drv_release_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_en) |-> (txd && $past(txd)));
endmodule

bind uart_tx_de uart_tx_de_chk u_chk (
  .clk(clk), .rst(rst), .txd(txd), .data_sent(data_sent),
  .tx_done(tx_done), .drv_en(drv_en)
);

// File: tb/tb_uart_tx_de.sv
module tb_uart_tx_de;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready;
  logic       baud_tick = 1'b0;
  logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic       txd, data_sent, tx_done, drv_en;

  int         errs = 0;
  int         checks = 0;
  int         frames = 0;
  bit         finished = 0;
  logic [7:0] exp_q [$];

  uart_tx_de dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .baud_tick(baud_tick), .par_en(par_en),
    .par_odd(par_odd), .two_stop(two_stop), .txd(txd),
    .data_sent(data_sent), .tx_done(tx_done), .drv_en(drv_en)
  );

  always #2.5 clk = ~clk;

  initial begin : tick_gen
    forever begin
      @(negedge clk);
      baud_tick = ~baud_tick;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    wr_valid = 1'b1;
    wr_data  = b;
    while (!wr_ready) @(negedge clk);
    exp_q.push_back(b);
    @(negedge clk);
  endtask

  task automatic wait_done();
    while (!tx_done) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic set_cfg(input logic pe, input logic po, input logic ts);
    par_en = pe; par_odd = po; two_stop = ts;
  endtask

  initial begin : monitor
    logic       prev;
    bit         have_start;
    bit         fin;
    logic [7:0] got, expb;
    int         nst;
    logic       pe, po;
    prev = 1'b1;
    have_start = 0;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      if (!have_start) begin
        @(negedge clk);
        if (!(prev && !txd)) begin
          prev = txd;
          continue;
        end
      end
      have_start = 0;
      pe = par_en; po = par_odd; nst = two_stop ? 2 : 1;
      repeat (16) @(negedge clk);
      chk(txd == 1'b0, "R2", "start bit level", txd, 0);
      chk(drv_en == 1'b1, "R7", "drv_en during start", drv_en, 1);
      chk(tx_done == 1'b0, "R6", "tx_done during start", tx_done, 0);
      for (int i = 0; i < 8; i++) begin
        repeat (32) @(negedge clk);
        got[i] = txd;
        if (i == 7) chk(data_sent == 1'b0, "R5", "data_sent in last data bit", data_sent, 0);
      end
      if (exp_q.size() == 0) begin
        chk(0, "R9", "frame with no byte written", got, -1);
        expb = got;
      end else begin
        expb = exp_q.pop_front();
      end
      chk(got == expb, "R2", "data byte LSB first", got, expb);
      fin = (exp_q.size() == 0) && !wr_valid;
      if (pe) begin
        repeat (32) @(negedge clk);
        chk(txd == ((^expb) ^ po), "R3", "parity bit", txd, (^expb) ^ po);
        chk(data_sent == fin, "R5", "data_sent during parity", data_sent, fin);
      end
      for (int s = 0; s < nst; s++) begin
        repeat (32) @(negedge clk);
        chk(txd == 1'b1, "R4", "stop bit level", txd, 1);
        if (s == 0 && !pe) chk(data_sent == fin, "R5", "data_sent during stop", data_sent, fin);
      end
      repeat (15) @(negedge clk);
      chk(tx_done == 1'b0, "R6", "tx_done before stop end", tx_done, 0);
      chk(txd == 1'b1, "R4", "stop bit still held", txd, 1);
      @(negedge clk);
      if (fin) begin
        chk(tx_done == 1'b1, "R6", "tx_done at stop end", tx_done, 1);
        chk(drv_en == 1'b0, "R7", "drv_en released at stop end", drv_en, 0);
        chk(txd == 1'b1, "R6", "line idle after done", txd, 1);
      end else begin
        chk(txd == 1'b0, "R9", "back-to-back start bit", txd, 0);
        chk(tx_done == 1'b0, "R6", "tx_done with queue non-empty", tx_done, 0);
        have_start = 1;
      end
      prev = txd;
      frames++;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : main
    int n;
    set_cfg(0, 0, 0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
    chk(tx_done == 1'b1, "R1", "tx_done after reset", tx_done, 1);
    chk(data_sent == 1'b1, "R1", "data_sent after reset", data_sent, 1);
    chk(drv_en == 1'b0, "R1", "drv_en after reset", drv_en, 0);
    chk(wr_ready == 1'b1, "R1", "wr_ready after reset", wr_ready, 1);

    // R8: write into an idle block, driver lead before start bit
    send(8'h55);
    wr_valid = 1'b0;
    chk(tx_done == 1'b0, "R8", "tx_done after accept", tx_done, 0);
    chk(data_sent == 1'b0, "R8", "data_sent after accept", data_sent, 0);
    chk(drv_en == 1'b1, "R8", "drv_en after accept", drv_en, 1);
    n = 0;
    while (txd && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n >= 32 && n <= 34, "R8", "lead cycles before start", n, 32);
    wait_done();

    set_cfg(1, 0, 0); send(8'hA3); wr_valid = 1'b0; wait_done();
    set_cfg(1, 1, 1); send(8'h00); wr_valid = 1'b0; wait_done();
    set_cfg(0, 0, 1); send(8'hFF); wr_valid = 1'b0; wait_done();
    set_cfg(1, 1, 0); send(8'h80); wr_valid = 1'b0; wait_done();

    // R9: fill the queue during the lead bit, then keep writing
    set_cfg(0, 0, 0);
    for (int i = 0; i < 8; i++) send(8'(i * 37 + 1));
    chk(wr_ready == 1'b0, "R9", "wr_ready with 8 queued", wr_ready, 0);
    send(8'hC6);
    send(8'h19);
    wr_valid = 1'b0;
    wait_done();

    chk(exp_q.size() == 0, "R9", "bytes left unsent", exp_q.size(), 0);
    chk(frames == 15, "R9", "frames observed", frames, 15);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule